// File: doc/BRIEF.md
# UART Loopback Signal Interconnect

This block sits between a UART core, its modem control register and the chip pins, and it provides the internal loopback path used for serial self-test. With loopback off, the receiver serial input comes from the wired or infrared receive pin, and the modem status lines come from the outside world. With loopback on, the external receive pins are ignored and the receiver is fed from the block's own transmitter output. The modem status lines are then driven from the modem control bits. How those bits are mapped depends on whether the extended mode is selected.

The transmit pins are parked in their idle levels during loopback, so that nothing leaves the chip. A keep-active option lets them run normally while the loopback path is in use. The block also keeps the modem status change flags. These are three "line changed" flags and one "ring indicator trailing edge" flag, and a status read clears all of them. They are never set just because loopback was switched on or off. A combined modem status interrupt request is produced from them, and it is muted in infrared mode when the modem-select bit is 1.

Top module: `uart_lb_link`

## Requirements
- R1: With `lb_en`=1, `rx_si` equals `ser_tx`, and both receive pins have no effect. With `lb_en`=0, `rx_si` equals `pin_rxd` when `ir_mode`=0 and the inverse of `pin_irrx` when `ir_mode`=1.
- R2: Normal transmit levels are as follows. With `ir_mode`=0, `pin_txd`=`ser_tx` and `pin_irtx`=0. With `ir_mode`=1, `pin_txd`=1 and `pin_irtx`=NOT `ser_tx`. These normal levels apply when `lb_en`=0, and also when `lb_en`=1 with `keep_tx`=1.
- R3: With `lb_en`=1 and `keep_tx`=0, `pin_txd`=1 and `pin_irtx`=0 whatever `ser_tx` is.
- R4: The modem lines follow the mode:
  - `lb_en`=1, `ext_mode`=1: `dsr`=`ri`=`mcr_dtr` and `cts`=`dcd`=`mcr_rts`.
  - `lb_en`=1, `ext_mode`=0: `cts`=`mcr_rts`, `dsr`=`mcr_dtr`, `ri`=`mcr_out1` and `dcd`=`mcr_out2`.
  - `lb_en`=0: each line equals its `ext_*` input.
- R5: `dlt_cts`, `dlt_dsr` and `dlt_dcd` become 1 in the cycle after the clock edge at which the corresponding line differs from its value at the previous edge. `trail_ri` becomes 1 only when `ri` goes from 1 to 0. Flags stay set until cleared.
- R6: No flag is set at the first edge after reset, nor at an edge where `lb_en` differs from its value at the previous edge. At both of these edges the previous-value registers are reloaded.
- R7: `msr_rd`=1 at an edge clears all four flags. A change detected at that same edge sets its flag anyway.
- R8: `msi` is 1 when any flag is 1, unless `ir_mode`=1 and `ir_msr_sel`=1, in which case it is 0.
- R9: After reset all four flags and `msi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_en | input | 1 | Loopback enable |
| ext_mode | input | 1 | Extended mode select |
| keep_tx | input | 1 | Keep transmit pins active during loopback |
| ir_mode | input | 1 | Infrared mode |
| ir_msr_sel | input | 1 | 1 mutes modem status interrupt in infrared mode |
| mcr_dtr | input | 1 | Modem control DTR bit |
| mcr_rts | input | 1 | Modem control RTS bit |
| mcr_out1 | input | 1 | Modem control OUT1 bit |
| mcr_out2 | input | 1 | Modem control OUT2 bit |
| ser_tx | input | 1 | Transmitter serial output |
| pin_rxd | input | 1 | Wired receive pin |
| pin_irrx | input | 1 | Infrared receive pin (1 = pulse) |
| ext_cts | input | 1 | External CTS |
| ext_dsr | input | 1 | External DSR |
| ext_ri | input | 1 | External RI |
| ext_dcd | input | 1 | External DCD |
| msr_rd | input | 1 | Modem status read strobe |
| rx_si | output | 1 | Receiver serial input |
| cts | output | 1 | Looped or external CTS |
| dsr | output | 1 | Looped or external DSR |
| ri | output | 1 | Looped or external RI |
| dcd | output | 1 | Looped or external DCD |
| pin_txd | output | 1 | Wired transmit pin |
| pin_irtx | output | 1 | Infrared transmit pin (1 = pulse) |
| dlt_cts | output | 1 | CTS changed flag |
| dlt_dsr | output | 1 | DSR changed flag |
| trail_ri | output | 1 | RI falling-edge flag |
| dlt_dcd | output | 1 | DCD changed flag |
| msi | output | 1 | Modem status interrupt request |

## Verification
Several behaviours are checked on every cycle by the assertions:
- the parked transmit levels;
- the paired modem lines in extended loopback;
- the flag register holding its value across a loopback switch;
- the setting of the trailing-edge flag after a 1-to-0 transition of RI;
- the flags clearing on a read when nothing changed.

Other behaviours need the bench's scenarios:
- whether the right source is selected for every mode combination;
- that a rising RI never sets its flag;
- that a change coinciding with a read survives it;
- that the first edge after reset stays quiet;
- that the interrupt is muted in infrared mode.

// File: rtl/uart_lb_link.sv
module uart_lb_link (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_en,
  input  logic ext_mode,
  input  logic keep_tx,
  input  logic ir_mode,
  input  logic ir_msr_sel,
  input  logic mcr_dtr,
  input  logic mcr_rts,
  input  logic mcr_out1,
  input  logic mcr_out2,
  input  logic ser_tx,
  input  logic pin_rxd,
  input  logic pin_irrx,
  input  logic ext_cts,
  input  logic ext_dsr,
  input  logic ext_ri,
  input  logic ext_dcd,
  input  logic msr_rd,
  output logic rx_si,
  output logic cts,
  output logic dsr,
  output logic ri,
  output logic dcd,
  output logic pin_txd,
  output logic pin_irtx,
  output logic dlt_cts,
  output logic dlt_dsr,
  output logic trail_ri,
  output logic dlt_dcd,
  output logic msi
);

  // bit order of line/prv/flg/chg: {dcd, ri, dsr, cts}
  logic [3:0] line, prv, flg, chg;
  logic       lb_q, primed, reload, park;

  assign cts = lb_en ? mcr_rts : ext_cts;
  assign dsr = lb_en ? mcr_dtr : ext_dsr;
  assign ri  = lb_en ? (ext_mode ? mcr_dtr : mcr_out1) : ext_ri;
  assign dcd = lb_en ? (ext_mode ? mcr_rts : mcr_out2) : ext_dcd;
  assign line = {dcd, ri, dsr, cts};

  assign rx_si = lb_en ? ser_tx : (ir_mode ? ~pin_irrx : pin_rxd);

  assign park     = lb_en & ~keep_tx;
  assign pin_txd  = park | ir_mode | ser_tx;
  assign pin_irtx = ~park & ir_mode & ~ser_tx;

  assign reload = ~primed | (lb_en != lb_q);
  assign chg = reload ? 4'b0000
             : {line[3] ^ prv[3], prv[2] & ~line[2], line[1] ^ prv[1], line[0] ^ prv[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      lb_q   <= 1'b0;
      prv    <= 4'b0000;
      flg    <= 4'b0000;
    end else begin
      primed <= 1'b1;
      lb_q   <= lb_en;
      prv    <= line;
      flg    <= (msr_rd ? 4'b0000 : flg) | chg;
    end
  end

  assign dlt_cts  = flg[0];
  assign dlt_dsr  = flg[1];
  assign trail_ri = flg[2];
  assign dlt_dcd  = flg[3];
  assign msi      = (|flg) & ~(ir_mode & ir_msr_sel);

  p_tx_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && !keep_tx) |-> (pin_txd && !pin_irtx));

  p_ext_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && ext_mode) |-> ((dsr == ri) && (cts == dcd) && (dsr == mcr_dtr) && (cts == mcr_rts)));

  p_switch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (lb_en != lb_q) && !msr_rd) |=> $stable({dlt_dcd, trail_ri, dlt_dsr, dlt_cts}));

  p_ri_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (lb_en == lb_q) && prv[2] && !ri) |=> trail_ri);

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && primed && (lb_en == lb_q) && (line == prv)) |=> !(dlt_cts || dlt_dsr || trail_ri || dlt_dcd));

endmodule

// File: tb/uart_lb_link_bench.sv
module uart_lb_link_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic lb_en, ext_mode, keep_tx, ir_mode, ir_msr_sel;
  logic mcr_dtr, mcr_rts, mcr_out1, mcr_out2, ser_tx, pin_rxd, pin_irrx;
  logic ext_cts, ext_dsr, ext_ri, ext_dcd, msr_rd;
  logic rx_si, cts, dsr, ri, dcd, pin_txd, pin_irtx;
  logic dlt_cts, dlt_dsr, trail_ri, dlt_dcd, msi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state, bit order {dcd, ri, dsr, cts}
  logic [3:0] m_prv, m_flg;
  logic       m_lbq, m_primed;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_lb_link u_uart_lb_link (
    .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .ext_mode(ext_mode), .keep_tx(keep_tx),
    .ir_mode(ir_mode), .ir_msr_sel(ir_msr_sel), .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts),
    .mcr_out1(mcr_out1), .mcr_out2(mcr_out2), .ser_tx(ser_tx), .pin_rxd(pin_rxd),
    .pin_irrx(pin_irrx), .ext_cts(ext_cts), .ext_dsr(ext_dsr), .ext_ri(ext_ri),
    .ext_dcd(ext_dcd), .msr_rd(msr_rd), .rx_si(rx_si), .cts(cts), .dsr(dsr), .ri(ri),
    .dcd(dcd), .pin_txd(pin_txd), .pin_irtx(pin_irtx), .dlt_cts(dlt_cts),
    .dlt_dsr(dlt_dsr), .trail_ri(trail_ri), .dlt_dcd(dlt_dcd), .msi(msi)
  );

  function automatic logic [3:0] exp_line();
    if (!lb_en) return {ext_dcd, ext_ri, ext_dsr, ext_cts};
    if (ext_mode) return {mcr_rts, mcr_dtr, mcr_dtr, mcr_rts};
    return {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};
  endfunction

  function automatic logic exp_rx();
    if (lb_en) return ser_tx;
    return ir_mode ? ~pin_irrx : pin_rxd;
  endfunction

  function automatic logic [1:0] exp_pins(); // {txd, irtx}
    if (lb_en && !keep_tx) return 2'b10;
    return ir_mode ? {1'b1, ~ser_tx} : {ser_tx, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_comb();
    logic [3:0] l;
    l = exp_line();
    chk(rx_si == exp_rx(), "R1 receive path", {3'b0, rx_si}, {3'b0, exp_rx()});
    chk({pin_txd, pin_irtx} == exp_pins(), (lb_en && !keep_tx) ? "R3 parked pins" : "R2 normal pins",
        {2'b0, pin_txd, pin_irtx}, {2'b0, exp_pins()});
    chk({dcd, ri, dsr, cts} == l, "R4 modem lines", {dcd, ri, dsr, cts}, l);
    chk(msi == ((|m_flg) && !(ir_mode && ir_msr_sel)), "R8 interrupt",
        {3'b0, msi}, {3'b0, ((|m_flg) && !(ir_mode && ir_msr_sel))});
  endtask

  task automatic step(input string tag);
    logic [3:0] l, c;
    logic rl;
    #1;
    chk_comb();
    l  = exp_line();
    rl = !m_primed || (lb_en != m_lbq);
    c  = rl ? 4'b0 : {l[3] ^ m_prv[3], m_prv[2] & ~l[2], l[1] ^ m_prv[1], l[0] ^ m_prv[0]};
    m_flg    = (msr_rd ? 4'b0 : m_flg) | c;
    m_prv    = l;
    m_lbq    = lb_en;
    m_primed = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({dlt_dcd, trail_ri, dlt_dsr, dlt_cts} == m_flg, tag,
        {dlt_dcd, trail_ri, dlt_dsr, dlt_cts}, m_flg);
  endtask

  task automatic all_zero();
    {lb_en, ext_mode, keep_tx, ir_mode, ir_msr_sel, mcr_dtr, mcr_rts, mcr_out1, mcr_out2} = '0;
    {ser_tx, pin_rxd, pin_irrx, ext_cts, ext_dsr, ext_ri, ext_dcd, msr_rd} = '0;
  endtask

  task automatic randomize_inputs();
    if (($urandom % 8) == 0) lb_en = ~lb_en;
    ext_mode = $urandom; keep_tx = $urandom; ir_mode = $urandom; ir_msr_sel = $urandom;
    if (($urandom % 3) == 0) {mcr_dtr, mcr_rts, mcr_out1, mcr_out2} = 4'($urandom);
    if (($urandom % 3) == 0) {ext_cts, ext_dsr, ext_ri, ext_dcd} = 4'($urandom);
    ser_tx = $urandom; pin_rxd = $urandom; pin_irrx = $urandom;
    msr_rd = (($urandom % 4) == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    all_zero();
    m_prv = '0; m_flg = '0; m_lbq = 1'b0; m_primed = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({dlt_dcd, trail_ri, dlt_dsr, dlt_cts, msi} == 5'b0, "R9 reset flags",
        {dlt_dcd, trail_ri, dlt_dsr, dlt_cts}, 4'b0);

    // R6: lines high at first edge after reset must not raise flags
    {ext_cts, ext_dsr, ext_ri, ext_dcd} = 4'b1111;
    step("R6 first edge quiet");
    // R5: falling RI sets trailing flag, others change-flags
    ext_ri = 1'b0; ext_cts = 1'b0;
    step("R5 ri fall and cts change");
    msr_rd = 1'b1; step("R7 read clears"); msr_rd = 1'b0;
    ext_ri = 1'b1; step("R5 ri rise no flag");
    // R7: change on read cycle survives
    msr_rd = 1'b1; ext_dsr = 1'b0; step("R7 change wins over read"); msr_rd = 1'b0;
    msr_rd = 1'b1; step("R7 clear again"); msr_rd = 1'b0;
    // R6: switch into loopback with differing lines
    {mcr_dtr, mcr_rts, mcr_out1, mcr_out2} = 4'b0000;
    lb_en = 1'b1; ext_mode = 1'b1;
    step("R6 switch on quiet");
    // R1/R3: loopback ignores receive pins, parks transmit pins
    ir_mode = 1'b0; pin_rxd = 1'b1; ser_tx = 1'b0; step("R1 loop ignores pin");
    ir_mode = 1'b1; pin_irrx = 1'b0; ser_tx = 1'b1; step("R3 parked ir");
    keep_tx = 1'b1; ser_tx = 1'b0; step("R2 keep active in loop");
    // R4/R5: extended mapping, dtr drives dsr and ri
    mcr_dtr = 1'b1; step("R4 R5 dtr rise ext");
    mcr_dtr = 1'b0; step("R4 R5 dtr fall ext ri trailing");
    // R8: interrupt muted in infrared with select=1
    ir_mode = 1'b1; ir_msr_sel = 1'b1; step("R8 muted");
    ir_msr_sel = 1'b0; step("R8 unmuted");
    // non-extended mapping
    ext_mode = 1'b0; mcr_out1 = 1'b1; mcr_out2 = 1'b1; step("R4 non-ext out lines");
    mcr_out1 = 1'b0; step("R5 out1 fall ri");
    lb_en = 1'b0; step("R6 switch off quiet");

    for (int i = 0; i < 600; i++) begin
      randomize_inputs();
      step("R5 R6 R7 random flags");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule